// File: doc/BRIEF.md
# DMA High-Address Page Register File

This block holds the byte-wide page registers that a 16-bit DMA controller needs to reach a 24-bit memory space. A host reaches it through a 32-byte I/O window with byte reads and writes. Every write lands in a sixteen-entry general byte array selected by the offset modulo 16. Four offsets in each group of eight also act as per-channel page bytes, and offset bit 3 picks one of two page sets, one per DMA controller.

The block watches the four active-low acknowledge lines of the first controller to learn which channel is being served. While a DMA cycle is in progress it drives a memory address built from that channel's page byte (first page set only) above the controller's 16-bit address. Outside a DMA cycle the address output is zero.

Top module: `dma_page_file`

## Requirements
- R1: After reset every general byte and every page byte reads as zero, and the current channel is 0.
- R2: A write with `io_wr` high stores `io_wdata` in general byte `io_ofs` modulo 16. Offsets 16 apart therefore share one byte, and a read at any offset returns the last byte written to that offset modulo 16.
- R3: Within each group of eight offsets the low three offset bits select page bytes as follows: 7 is channel 0, 3 is channel 1, 1 is channel 2, 2 is channel 3. Offsets 0, 4, 5 and 6 carry no page byte.
- R4: Offset bit 3 selects the page set: 0 addresses the set used for DMA address generation, 1 addresses the second set, which never reaches `mem_addr`.
- R5: A read at a page offset returns that page byte, and a read at any other offset returns the general byte. `io_rd_data` is combinational from `io_ofs`.
- R6: With `io_wr` low no register changes, whatever `io_ofs` and `io_wdata` carry.
- R7: The current channel becomes k in the cycle where `dack_n[k]` is first seen low after being high. It is registered at the next clock edge. A line that stays low or returns high does not change it.
- R8: When several acknowledge lines fall in the same cycle, the lowest-numbered one becomes the current channel.
- R9: With `dma_active` high, `mem_addr` is the first-set page byte of the channel in bits 23:16 and `ctl_addr` in bits 15:0. In the cycle of a falling acknowledge the new channel is used at once.
- R10: With `dma_active` low, `mem_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_ofs | input | 5 | Byte offset inside the I/O window |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_wdata | input | 8 | Write data |
| io_rd_data | output | 8 | Read data for `io_ofs` |
| dack_n | input | 4 | Active-low acknowledge per channel of the first controller |
| dma_active | input | 1 | A DMA memory cycle is in progress |
| ctl_addr | input | 16 | Low address from the DMA controller |
| mem_addr | output | 24 | Full DMA memory address |

## Verification
The assertions assume the acknowledge lines are synchronous to `clk` and are sampled only after reset, with `dack_n` at all ones during reset, so the first edge seen is a real fall. The stimulus changes every input only at the falling clock edge. It holds `dack_n` high through reset and returns the lines high between channel scenarios, so that each fall the bench expects is clean. The offset sweep covers all 32 offsets with distinct data. The two page sets can then be told apart by the address they produce.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

   localparam int CH_N  = 4;
   localparam int CH_W  = 2;
   localparam int SET_N = 2;

   typedef struct packed {
      logic            hit;
      logic [CH_W-1:0] ch;
   } page_sel_t;

   // Offset-within-group to channel map; the order is fixed by the bus.
   function automatic page_sel_t decode_page(input logic [2:0] low3);
      page_sel_t r;
      r = '0;
      case (low3)
         3'd7: begin r.hit = 1'b1; r.ch = 2'd0; end
         3'd3: begin r.hit = 1'b1; r.ch = 2'd1; end
         3'd1: begin r.hit = 1'b1; r.ch = 2'd2; end
         3'd2: begin r.hit = 1'b1; r.ch = 2'd3; end
         default: r = '0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/dpf_regs.sv
module dpf_regs
   import dpf_pkg::*;
#(
   parameter int OFS_W  = 5,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OFS_W-1:0]  io_ofs,
   input  logic              io_wr,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rd_data,
   input  logic [CH_W-1:0]   dma_ch,
   output logic [DATA_W-1:0] dma_page
);

   localparam int SEL_BIT = 3;
   localparam int IDX_W   = SEL_BIT + 1;
   localparam int SCR_D   = 1 << IDX_W;

   generate
      if (OFS_W < IDX_W) begin : g_bad_ofs
         $error("dpf_regs: OFS_W must be at least %0d", IDX_W);
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dpf_regs: DATA_W must be positive");
      end
   endgenerate

   logic [SCR_D-1:0][DATA_W-1:0]            scr_q;
   logic [SET_N-1:0][CH_N-1:0][DATA_W-1:0]  pg_q;

   logic [IDX_W-1:0] idx;
   logic             set_sel;
   page_sel_t        dec;

   always_comb begin
      idx     = IDX_W'(io_ofs % SCR_D);
      set_sel = io_ofs[SEL_BIT];
      dec     = decode_page(io_ofs[2:0]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scr_q <= '0;
         pg_q  <= '0;
      end else if (io_wr) begin
         scr_q[idx] <= io_wdata;
         for (int s = 0; s < SET_N; s++) begin
            for (int c = 0; c < CH_N; c++) begin
               if (dec.hit && (dec.ch == CH_W'(c)) && (set_sel == s[0]))
                  pg_q[s][c] <= io_wdata;
            end
         end
      end
   end

   always_comb begin
      if (dec.hit) io_rd_data = pg_q[set_sel][dec.ch];
      else         io_rd_data = scr_q[idx];
      dma_page = pg_q[0][dma_ch];
   end

   AST_SCR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      io_wr |=> scr_q[$past(idx)] == $past(io_wdata)); // R2
   AST_NO_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !io_wr |=> $stable(scr_q) && $stable(pg_q)); // R6
   AST_PAGE_CH0: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_ofs[3:0] == 4'h7) |=> pg_q[0][0] == $past(io_wdata)); // R3

endmodule

// File: rtl/dpf_chan.sv
module dpf_chan
   import dpf_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CH_N-1:0] dack_n,
   output logic [CH_W-1:0] eff_ch
);

   logic [CH_N-1:0] prev_q;
   logic [CH_N-1:0] fall;
   logic [CH_W-1:0] cur_q;
   logic [CH_W-1:0] low_ch;

   generate
      for (genvar k = 0; k < CH_N; k++) begin : g_edge
         assign fall[k] = prev_q[k] & ~dack_n[k];
      end
   endgenerate

   always_comb begin
      low_ch = '0;
      for (int k = CH_N - 1; k >= 0; k--) begin
         if (fall[k]) low_ch = CH_W'(k);
      end
      eff_ch = (|fall) ? low_ch : cur_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '1;
         cur_q  <= '0;
      end else begin
         prev_q <= dack_n;
         cur_q  <= eff_ch;
      end
   end

   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      fall[0] |=> cur_q == '0); // R8
   AST_CH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fall == '0) |=> $stable(cur_q)); // R7

endmodule

// File: rtl/dpf_addr.sv
module dpf_addr #(
   parameter int DATA_W = 8,
   parameter int CA_W   = 16
) (
   input  logic                     dma_active,
   input  logic [DATA_W-1:0]        page,
   input  logic [CA_W-1:0]          ctl_addr,
   output logic [DATA_W+CA_W-1:0]   mem_addr
);

   generate
      if (CA_W < 1) begin : g_bad_ca
         $error("dpf_addr: CA_W must be positive");
      end
   endgenerate

   always_comb begin
      if (dma_active) mem_addr = {page, ctl_addr};
      else            mem_addr = '0;
   end

endmodule

// File: rtl/dma_page_file.sv
module dma_page_file
   import dpf_pkg::*;
#(
   parameter int OFS_W  = 5,
   parameter int DATA_W = 8,
   parameter int CA_W   = 16,
   localparam int PA_W  = DATA_W + CA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OFS_W-1:0]  io_ofs,
   input  logic              io_wr,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rd_data,
   input  logic [CH_N-1:0]   dack_n,
   input  logic              dma_active,
   input  logic [CA_W-1:0]   ctl_addr,
   output logic [PA_W-1:0]   mem_addr
);

   logic [CH_W-1:0]   eff_ch;
   logic [DATA_W-1:0] dma_page;

   dpf_regs #(.OFS_W(OFS_W), .DATA_W(DATA_W)) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .io_ofs     (io_ofs),
      .io_wr      (io_wr),
      .io_wdata   (io_wdata),
      .io_rd_data (io_rd_data),
      .dma_ch     (eff_ch),
      .dma_page   (dma_page)
   );

   dpf_chan chan_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .dack_n (dack_n),
      .eff_ch (eff_ch)
   );

   dpf_addr #(.DATA_W(DATA_W), .CA_W(CA_W)) addr_i (
      .dma_active (dma_active),
      .page       (dma_page),
      .ctl_addr   (ctl_addr),
      .mem_addr   (mem_addr)
   );

   AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      dma_active |-> mem_addr[CA_W-1:0] == ctl_addr); // R9

endmodule

// File: tb/dma_page_file_tb.sv
module dma_page_file_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  io_ofs = '0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rd_data;
   logic [3:0]  dack_n = 4'hF;
   logic        dma_active = 1'b0;
   logic [15:0] ctl_addr = '0;
   logic [23:0] mem_addr;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] bscr [16];
   bit done = 1'b0;

   always #5 clk = ~clk;

   dma_page_file dut_i (
      .clk(clk), .rst_n(rst_n), .io_ofs(io_ofs), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rd_data(io_rd_data), .dack_n(dack_n),
      .dma_active(dma_active), .ctl_addr(ctl_addr), .mem_addr(mem_addr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int page_ofs(input int c);
      case (c)
         0: return 7;
         1: return 3;
         2: return 1;
         default: return 2;
      endcase
   endfunction

   task automatic write_b(input int o, input logic [7:0] d);
      @(negedge clk);
      io_ofs = 5'(o); io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic read_chk(input string req, input int o, input logic [7:0] e);
      @(negedge clk);
      io_ofs = 5'(o);
      #1;
      chk(req, 32'(io_rd_data), 32'(e));
   endtask

   initial begin
      #(10 * 100000);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset contents and channel
      for (int o = 0; o < 32; o++) read_chk("R1", o, 8'h00);
      @(negedge clk);
      dma_active = 1'b1; ctl_addr = 16'h5A5A;
      #1 chk("R1", 32'(mem_addr), 32'h005A5A);
      dma_active = 1'b0;

      // R2/R3: sweep writes over the whole window
      for (int o = 0; o < 32; o++) begin
         logic [7:0] d;
         d = 8'((o * 37 + 5) & 255);
         write_b(o, d);
         bscr[o % 16] = d;
      end
      // R2/R5: read back every offset
      for (int o = 0; o < 32; o++) read_chk("R2_R5", o, bscr[o % 16]);

      // R6: write strobe low leaves state
      @(negedge clk);
      io_ofs = 5'd5; io_wdata = 8'hEE; io_wr = 1'b0;
      @(negedge clk);
      read_chk("R6", 5, bscr[5]);
      read_chk("R6", 21, bscr[5]);

      // R3/R4/R9: each channel alone, first page set
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         dma_active = 1'b1; ctl_addr = 16'hA000 + 16'(c);
         dack_n = ~(4'b1 << c);
         #1 chk("R3_R4_R9", 32'(mem_addr), {8'h0, bscr[page_ofs(c)], 16'hA000 + 16'(c)});
         @(negedge clk);
         dack_n = 4'hF;
         #1 chk("R7", 32'(mem_addr), {8'h0, bscr[page_ofs(c)], 16'hA000 + 16'(c)});
      end

      // R10: idle address is zero
      @(negedge clk);
      dma_active = 1'b0;
      #1 chk("R10", 32'(mem_addr), 32'h0);

      // R8: simultaneous falls, lowest wins
      @(negedge clk);
      dma_active = 1'b1; ctl_addr = 16'h0102;
      dack_n = 4'b0101;
      #1 chk("R8", 32'(mem_addr), {8'h0, bscr[page_ofs(1)], 16'h0102});
      @(negedge clk);
      dack_n = 4'hF;
      @(negedge clk);
      dack_n = 4'b0110;
      #1 chk("R8", 32'(mem_addr), {8'h0, bscr[page_ofs(0)], 16'h0102});

      // R7: line already low does not compete with a fresh fall
      @(negedge clk);
      dack_n = 4'hF;
      @(negedge clk);
      dack_n = 4'b1011;
      @(negedge clk);
      dack_n = 4'b0011;
      #1 chk("R7", 32'(mem_addr), {8'h0, bscr[page_ofs(3)], 16'h0102});
      @(negedge clk);
      #1 chk("R7", 32'(mem_addr), {8'h0, bscr[page_ofs(3)], 16'h0102});

      // R4: rewrite second set channel 0; first set output unchanged
      @(negedge clk);
      dack_n = 4'hF;
      write_b(15, 8'hC3);
      bscr[15] = 8'hC3;
      @(negedge clk);
      dack_n = 4'b1110;
      #1 chk("R4", 32'(mem_addr), {8'h0, bscr[7], 16'h0102});
      read_chk("R4", 31, 8'hC3);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule